// File: doc/BRIEF.md
# Paged Microcontroller Memory Window Arbiter

This block lets an 8-bit microcontroller with a 16-bit byte address reach a frame buffer memory much larger than its own address space. The lower half of the microcontroller's space (0x0000 to 0x7FFF) is a 32 KB window that software moves in 32 KB steps by writing a page register. Three 4 KB windows sit above it. They point at the frame named by a software-written frame number register, at the frame after it and at the frame two beyond it. Frames are 4 KB, so code working on a stream of frames can move forward by changing one register.

Each microcontroller access is a single byte read or write. The block turns it into one request to the shared memory arbiter, with the physical address, the direction and the write byte. It holds the microcontroller in wait states until the arbiter grants the cycle. Other requesters may hold the memory for up to four 5-clock access cycles, so the wait can last up to about 20 clocks. Every access costs at least one wait state. Addresses from 0xB000 upward map to nothing: a read there returns zero after a single wait state, and no memory request is made.

Top module: `uc_window_arb`

## Requirements
- R1: After synchronous reset, cpu_wait, mem_req and cpu_rdata are 0, and both the page register and the frame register are 0.
- R2: A cpu_addr below 0x8000 (bit 15 clear) maps to physical address {page, cpu_addr[14:0]}, with a 5-bit page and a 20-bit physical address by default.
- R3: cpu_addr[15:12] equal to 0x8, 0x9 or 0xA maps to physical address {(frame + k) mod 2^FR_W, cpu_addr[11:0]}, where k is 0, 1 or 2 respectively and FR_W is 8 by default. A frame number near the top of its range therefore wraps to frame 0 and up.
- R4: An accepted cpu_req raises cpu_wait on the next clock edge, so there is always at least one wait state. For a mapped address, mem_req rises at the same edge.
- R5: While mem_req is high and mem_ack is low, mem_req, mem_addr, mem_we and mem_wdata stay unchanged. At the edge where mem_ack is sampled high, mem_req and cpu_wait both fall. For a read, cpu_rdata takes mem_rdata at that same edge.
- R6: An access with cpu_addr at or above 0xB000 never raises mem_req and holds cpu_wait for exactly one cycle. A read there sets cpu_rdata to 0.
- R7: A cpu_req made while cpu_wait is high is ignored. It starts no further access.
- R8: Writes to the page or frame register made during an access do not change the address of that access. They take effect from the next access on.
- R9: A write access drives mem_we=1 and mem_wdata=cpu_wdata and leaves cpu_rdata unchanged. A read access drives mem_we=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle access strobe from the microcontroller |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 16 | Microcontroller byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid once cpu_wait falls |
| cpu_wait | output | 1 | Wait state request to the microcontroller |
| page_we | input | 1 | Load the page register |
| page_val | input | PG_W (5) | New page value |
| frame_we | input | 1 | Load the frame number register |
| frame_val | input | FR_W (8) | New frame number |
| mem_req | output | 1 | Byte access request to the memory arbiter |
| mem_we | output | 1 | Direction of the request |
| mem_addr | output | PA_W (20) | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | One-cycle grant marking completion of the request |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |

## Verification
The bench probes both ends of each window: page 31 at offset zero, the last byte of a page, and frame numbers 0xFE and 0xFF in the +1 and +2 windows. A design that carried the frame sum into the page bits, or did not wrap it, would put those accesses outside the frame area. The grant arrives anywhere from the first request cycle up to 19 cycles later, so a design that dropped wait early or late, or latched read data off the grant edge, shows up as a wrong wait count or wrong data. Further tests issue an unmapped read, which must not raise a request. They also send a second strobe during a wait, which a design without the busy guard would start as an extra access. Finally they change the page and frame mid-access, which exposes a design that decodes live rather than from a captured address.

// File: rtl/uwa_pkg.sv
package uwa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_HOLD = 2'd2
  } acc_state_t;

  typedef enum logic [1:0] {
    RG_PAGE  = 2'd0,
    RG_FRAME = 2'd1,
    RG_NONE  = 2'd2
  } region_t;
endpackage

// File: rtl/uwa_decode.sv
module uwa_decode
  import uwa_pkg::*;
#(
  parameter int PA_W = 20,
  localparam int PG_W = PA_W - 15,
  localparam int FR_W = PA_W - 12
) (
  input  logic [PG_W-1:0] page,
  input  logic [FR_W-1:0] frame,
  input  logic [15:0]     cpu_addr,
  output region_t         region,
  output logic [PA_W-1:0] phys
);
  logic [3:0]      nib;
  logic [FR_W-1:0] fsel;

  always_comb begin
    nib    = cpu_addr[15:12];
    fsel   = frame + FR_W'(nib - 4'd8);
    region = RG_NONE;
    phys   = '0;
    if (!cpu_addr[15]) begin
      region = RG_PAGE;
      phys   = {page, cpu_addr[14:0]};
    end else if (nib <= 4'hA) begin
      region = RG_FRAME;
      phys   = {fsel, cpu_addr[11:0]};
    end
  end
endmodule

// File: rtl/uwa_access.sv
module uwa_access
  import uwa_pkg::*;
#(
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_we,
  input  logic            start_map,
  input  logic [PA_W-1:0] start_addr,
  input  logic [7:0]      start_wdata,
  input  logic            mem_ack,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic [7:0]      rdata
);
  acc_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rdata     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          busy      <= 1'b1;
          mem_we    <= start_we;
          mem_addr  <= start_addr;
          mem_wdata <= start_wdata;
          if (start_map) begin
            mem_req <= 1'b1;
            state   <= ST_MEM;
          end else begin
            state   <= ST_HOLD;
          end
        end
        ST_MEM: if (mem_ack) begin
          mem_req <= 1'b0;
          busy    <= 1'b0;
          if (!mem_we) rdata <= mem_rdata;
          state   <= ST_IDLE;
        end
        ST_HOLD: begin
          busy <= 1'b0;
          if (!mem_we) rdata <= '0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: a memory request is never outstanding without a wait state
  a_r4_req_implies_wait: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R5: request held steady until granted
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R5: grant releases both the request and the wait
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (!mem_req && !busy));

  // R6: a wait without a memory request lasts a single cycle
  a_r6_short_wait: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_req) |=> !busy);

  // R9: a write access never alters the read byte
  a_r9_write_keeps_rdata: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_we) |=> $stable(rdata));
endmodule

// File: rtl/uc_window_arb.sv
module uc_window_arb
  import uwa_pkg::*;
#(
  parameter int PA_W = 20,
  localparam int PG_W = PA_W - 15,
  localparam int FR_W = PA_W - 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [15:0]     cpu_addr,
  input  logic [7:0]      cpu_wdata,
  output logic [7:0]      cpu_rdata,
  output logic            cpu_wait,
  input  logic            page_we,
  input  logic [PG_W-1:0] page_val,
  input  logic            frame_we,
  input  logic [FR_W-1:0] frame_val,
  output logic            mem_req,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic            mem_ack,
  input  logic [7:0]      mem_rdata
);
  logic [PG_W-1:0] page_q;
  logic [FR_W-1:0] frame_q;
  region_t         region;
  logic [PA_W-1:0] phys;
  logic            accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      frame_q <= '0;
    end else begin
      if (page_we)  page_q  <= page_val;
      if (frame_we) frame_q <= frame_val;
    end
  end

  uwa_decode #(.PA_W(PA_W)) dec_i (
    .page     (page_q),
    .frame    (frame_q),
    .cpu_addr (cpu_addr),
    .region   (region),
    .phys     (phys)
  );

  assign accept = cpu_req && !cpu_wait;

  uwa_access #(.PA_W(PA_W)) acc_i (
    .clk         (clk),
    .rst         (rst),
    .start       (accept),
    .start_we    (cpu_we),
    .start_map   (region != RG_NONE),
    .start_addr  (phys),
    .start_wdata (cpu_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .busy        (cpu_wait),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .rdata       (cpu_rdata)
  );

  // R4: an accepted strobe raises the wait on the following edge
  a_r4_wait_follows_req: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_wait) |=> cpu_wait);

  // R6: strobes into the unmapped range never reach memory
  a_r6_unmapped_no_req: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_wait && cpu_addr >= 16'hB000) |=> !mem_req);
endmodule

// File: tb/uc_window_arb_tb.sv
module uc_window_arb_tb_top;
  localparam int PA_W = 20;

  typedef struct packed {
    logic        we;
    logic [4:0]  page;
    logic [7:0]  frame;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [19:0] exp;
    logic [4:0]  dly;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 5'd0,  8'h00, 16'h1234, 8'h00, 20'h01234, 5'd0},
    '{1'b0, 5'd3,  8'h00, 16'h7FFF, 8'h00, 20'h1FFFF, 5'd3},
    '{1'b1, 5'd31, 8'h00, 16'h0000, 8'hA5, 20'hF8000, 5'd1},
    '{1'b0, 5'd31, 8'h05, 16'h8ABC, 8'h00, 20'h05ABC, 5'd19},
    '{1'b1, 5'd31, 8'h05, 16'h9001, 8'h3C, 20'h06001, 5'd7},
    '{1'b0, 5'd31, 8'h05, 16'hAFFF, 8'h00, 20'h07FFF, 5'd2},
    '{1'b0, 5'd0,  8'hFF, 16'h9010, 8'h00, 20'h00010, 5'd4},
    '{1'b0, 5'd0,  8'hFE, 16'hA020, 8'h00, 20'h00020, 5'd0},
    '{1'b0, 5'd0,  8'hFF, 16'h8000, 8'h00, 20'h0FF000 & 20'hFFFFF, 5'd10},
    '{1'b1, 5'd1,  8'h02, 16'hA7C0, 8'h81, 20'h047C0, 5'd5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_wait;
  logic        page_we = 1'b0;
  logic [4:0]  page_val = '0;
  logic        frame_we = 1'b0;
  logic [7:0]  frame_val = '0;
  logic        mem_req, mem_we;
  logic [PA_W-1:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] last_rd = '0;

  always #5 clk = ~clk;

  uc_window_arb #(.PA_W(PA_W)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .page_we(page_we), .page_val(page_val),
    .frame_we(frame_we), .frame_val(frame_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_regs(input logic [4:0] pg, input logic [7:0] fr);
    @(negedge clk);
    page_we = 1'b1; page_val = pg; frame_we = 1'b1; frame_val = fr;
    @(negedge clk);
    page_we = 1'b0; frame_we = 1'b0;
  endtask

  // issue one strobe; returns at the negedge right after it was sampled
  task automatic strobe(input logic we, input logic [15:0] a,
                        input logic [7:0] wd);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 wait", cpu_wait, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 rdata", cpu_rdata, 0);
    strobe(1'b0, 16'h4321, 8'h00);
    check("R1 page/R2 addr", mem_addr, 20'h04321);
    mem_ack = 1'b1; mem_rdata = 8'h11;
    @(negedge clk);
    mem_ack = 1'b0;
    last_rd = 8'h11;
    strobe(1'b0, 16'h8123, 8'h00);
    check("R1 frame/R3 addr", mem_addr, 20'h00123);
    mem_ack = 1'b1; mem_rdata = 8'h22;
    @(negedge clk);
    mem_ack = 1'b0;
    last_rd = 8'h22;

    // table walk: R2 R3 R4 R5 R9
    foreach (VEC[i]) begin
      vec_t v = VEC[i];
      logic [7:0] rv = v.addr[7:0] ^ 8'h5A;
      set_regs(v.page, v.frame);
      strobe(v.we, v.addr, v.wdata);
      check("R4 wait rises", cpu_wait, 1);
      check("R4 mem_req rises", mem_req, 1);
      check(v.addr[15] ? "R3 frame addr" : "R2 page addr", mem_addr, v.exp);
      check("R9 direction", mem_we, v.we);
      if (v.we) check("R9 wdata", mem_wdata, v.wdata);
      for (int d = 0; d < int'(v.dly); d++) begin
        @(negedge clk);
        if (d == int'(v.dly) - 1) begin
          check("R5 wait held", cpu_wait, 1);
          check("R5 addr stable", mem_addr, v.exp);
        end
      end
      mem_ack = 1'b1; mem_rdata = rv;
      @(negedge clk);
      mem_ack = 1'b0; mem_rdata = 8'h00;
      check("R5 wait released", cpu_wait, 0);
      check("R5 req released", mem_req, 0);
      if (v.we) begin
        check("R9 rdata kept", cpu_rdata, last_rd);
      end else begin
        check("R5 read data", cpu_rdata, rv);
        last_rd = rv;
      end
    end

    // R6: unmapped read
    strobe(1'b0, 16'hC000, 8'h00);
    check("R6 wait one cycle", cpu_wait, 1);
    check("R6 no request", mem_req, 0);
    @(negedge clk);
    check("R6 wait dropped", cpu_wait, 0);
    check("R6 no request after", mem_req, 0);
    check("R6 rdata zero", cpu_rdata, 0);
    strobe(1'b0, 16'hFFFF, 8'h00);
    check("R6 top no request", mem_req, 0);
    @(negedge clk);
    check("R6 top wait dropped", cpu_wait, 0);

    // R7 and R8: strobe and register writes during an access
    set_regs(5'd2, 8'h10);
    strobe(1'b0, 16'h9100, 8'h00);
    check("R8 start addr", mem_addr, 20'h11100);
    cpu_req = 1'b1; cpu_addr = 16'h0100;
    page_we = 1'b1; page_val = 5'd9; frame_we = 1'b1; frame_val = 8'h40;
    @(negedge clk);
    cpu_req = 1'b0; page_we = 1'b0; frame_we = 1'b0;
    check("R8 addr unchanged", mem_addr, 20'h11100);
    mem_ack = 1'b1; mem_rdata = 8'h77;
    @(negedge clk);
    mem_ack = 1'b0;
    check("R5 rdata", cpu_rdata, 8'h77);
    @(negedge clk);
    check("R7 no second access req", mem_req, 0);
    check("R7 no second access wait", cpu_wait, 0);
    strobe(1'b0, 16'h8000, 8'h00);
    check("R8 new frame used next", mem_addr, 20'h40000);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    strobe(1'b0, 16'h0001, 8'h00);
    check("R8 new page used next", mem_addr, 20'h48001);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;

    // R1: reset mid-access clears everything
    strobe(1'b0, 16'h2000, 8'h00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset wait", cpu_wait, 0);
    check("R1 reset req", mem_req, 0);
    check("R1 reset rdata", cpu_rdata, 0);
    summary();
  end
endmodule